// File: doc/BRIEF.md
# Hart Debug Trigger Unit (Instruction Count, Interrupt, Exception)

This block sits next to a hart's retire and trap logic and decides when the hart must stop and enter debug mode. It has three independent triggers. The count trigger counts retired instructions down to zero. The interrupt trigger watches taken interrupts. The exception trigger watches taken exceptions. Each trigger is limited to the privilege modes a debugger has enabled for it. When any trigger fires, the block raises a registered halt request together with a per-trigger hit vector.

Configuration arrives as single-cycle writes. A write picks one trigger and loads its mode enables and its count or cause mask. For the count trigger the write also loads the pending flag, and for the interrupt trigger it loads the NMI option. A clear write empties the selected trigger in one cycle. Every cycle the hart reports three things: whether an instruction retired, whether an interrupt or exception was taken (with its cause code and an NMI flag), and its current privilege mode and debug state.

Top module: `dbg_trig_unit`

## Requirements
- R1: After a synchronous reset `halt_req_o` and `hit_o` are 0, and every trigger is empty: no event fires until a trigger has been written.
- R2: `priv_i` encodes the current mode as 3=M, 1=S, 0=U, 5=VS, 4=VU. Mode-enable bits are bit0=M, bit1=S, bit2=U, bit3=VS, bit4=VU. A trigger fires only while the bit for the current mode is set.
- R3: The exception trigger (`cfg_sel_i`=3) fires when `exc_taken_i` is high and bit `cause_i` of its mask is set. It reports this as `hit_o[2]` one clock edge after the event.
- R4: The interrupt trigger (`cfg_sel_i`=2) fires when `irq_taken_i` is high, `irq_nmi_i` is low and bit `cause_i` of its mask is set. It reports this as `hit_o[1]` one edge after the event.
- R5: A non-maskable interrupt (`irq_taken_i` and `irq_nmi_i` both high) fires the interrupt trigger only if its NMI option was written as 1. The mask is then ignored.
- R6: The count trigger (`cfg_sel_i`=1) is loaded with N in `cfg_data_i`. It counts down once per retirement in an enabled mode. `hit_o[0]` rises one edge after the edge that takes the Nth counted retirement.
- R7: When the count reaches zero, the pending flag sets and stays set until the trigger is rewritten or cleared. While pending, `hit_o[0]` stays high. Writing the pending flag directly makes `hit_o[0]` rise two edges after the write. A count of 0 written with pending 0 never fires.
- R8: While `debug_mode_i` is high, no trigger fires and retirements are not counted. A pending count trigger fires again once debug mode is left.
- R9: A clear write (`cfg_clear_i`=1) zeroes the selected trigger's mode enables, its mask or count, and its pending or NMI flag at one edge. Later events do not fire it.
- R10: `halt_req_o` is high exactly when at least one `hit_o` bit is high. When the interrupt and exception triggers fire in the same cycle, both hit bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Trigger select: 1 count, 2 interrupt, 3 exception |
| cfg_clear_i | input | 1 | Write clears the selected trigger |
| cfg_modes_i | input | 5 | Mode enables (bit0 M, bit1 S, bit2 U, bit3 VS, bit4 VU) |
| cfg_nmi_i | input | 1 | NMI option for the interrupt trigger |
| cfg_pending_i | input | 1 | Pending flag loaded into the count trigger |
| cfg_data_i | input | 2**CAUSE_W | Cause mask, or count in the low CNT_W bits |
| retire_i | input | 1 | An instruction retired this cycle |
| irq_taken_i | input | 1 | An interrupt was taken this cycle |
| irq_nmi_i | input | 1 | The taken interrupt is non-maskable |
| exc_taken_i | input | 1 | An exception was taken this cycle |
| cause_i | input | CAUSE_W | Cause code of the taken trap |
| priv_i | input | 3 | Current privilege mode code |
| debug_mode_i | input | 1 | Hart is in debug mode |
| halt_req_o | output | 1 | Registered debug halt request |
| hit_o | output | 3 | Registered hits: bit0 count, bit1 interrupt, bit2 exception |

## Verification
The bench probes the mode decode with codes for adjacent or virtualised modes. A decoder that confused VS with S, or that ignored the enables, would raise hits in modes the debugger excluded. It counts a retirement exactly at the limit and mixes in retirements from disabled modes and from debug mode. A counter that was off by one, or that counted foreign retirements, would move the hit by a cycle. It also checks that a cleared trigger stays silent, that a pending count trigger stays high and resumes after debug mode, and that an NMI bypasses the mask only when the option is set. A unit that lost the pending state, or that let an NMI match through mask bit 0, would fail these checks.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int NUM_MODES = 5;
  localparam int NUM_TRIG  = 3;

  // privilege mode codes on priv_i
  localparam logic [2:0] PRIV_U  = 3'd0;
  localparam logic [2:0] PRIV_S  = 3'd1;
  localparam logic [2:0] PRIV_M  = 3'd3;
  localparam logic [2:0] PRIV_VU = 3'd4;
  localparam logic [2:0] PRIV_VS = 3'd5;

  // positions in the mode-enable vector
  localparam int EN_M  = 0;
  localparam int EN_S  = 1;
  localparam int EN_U  = 2;
  localparam int EN_VS = 3;
  localparam int EN_VU = 4;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_IRQ   = 2'd2,
    SEL_EXC   = 2'd3
  } trig_sel_e;

  localparam int HIT_COUNT = 0;
  localparam int HIT_IRQ   = 1;
  localparam int HIT_EXC   = 2;
endpackage

// File: rtl/dbg_trig_mode_dec.sv
module dbg_trig_mode_dec
  import dbg_trig_pkg::*;
(
  input  logic [2:0]           priv_i,
  output logic [NUM_MODES-1:0] mode_oh_o
);
  always_comb begin
    mode_oh_o = '0;
    case (priv_i)
      PRIV_M:  mode_oh_o[EN_M]  = 1'b1;
      PRIV_S:  mode_oh_o[EN_S]  = 1'b1;
      PRIV_U:  mode_oh_o[EN_U]  = 1'b1;
      PRIV_VS: mode_oh_o[EN_VS] = 1'b1;
      PRIV_VU: mode_oh_o[EN_VU] = 1'b1;
      default: mode_oh_o = '0;
    endcase
  end
endmodule

// File: rtl/dbg_trig_icount.sv
module dbg_trig_icount
  import dbg_trig_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic                 clr_i,
  input  logic [NUM_MODES-1:0] wr_modes_i,
  input  logic                 wr_pend_i,
  input  logic [CNT_W-1:0]     wr_count_i,
  input  logic                 retire_i,
  input  logic [NUM_MODES-1:0] mode_oh_i,
  input  logic                 dbg_i,
  output logic                 fire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NUM_MODES-1:0] modes_q;
  logic [CNT_W-1:0]     count_q;
  logic                 pend_q;
  logic                 counted;

  assign counted = retire_i && !dbg_i && |(modes_q & mode_oh_i) && (count_q != '0);
  assign fire_o  = !dbg_i && (pend_q || (counted && count_q == ONE));

  always_ff @(posedge clk) begin
    if (rst) begin
      modes_q <= '0;
      count_q <= '0;
      pend_q  <= 1'b0;
    end else if (wr_i) begin
      modes_q <= clr_i ? '0 : wr_modes_i;
      count_q <= clr_i ? '0 : wr_count_i;
      pend_q  <= clr_i ? 1'b0 : wr_pend_i;
    end else if (counted) begin
      count_q <= count_q - ONE;
      if (count_q == ONE) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_trig_cause.sv
module dbg_trig_cause
  import dbg_trig_pkg::*;
#(
  parameter int CAUSE_W = 5,
  parameter bit HAS_NMI = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_i,
  input  logic                    clr_i,
  input  logic [NUM_MODES-1:0]    wr_modes_i,
  input  logic [(1<<CAUSE_W)-1:0] wr_mask_i,
  input  logic                    wr_nmi_i,
  input  logic                    ev_i,
  input  logic                    ev_nmi_i,
  input  logic [CAUSE_W-1:0]      cause_i,
  input  logic [NUM_MODES-1:0]    mode_oh_i,
  input  logic                    dbg_i,
  output logic                    fire_o
);
  localparam int MASK_W = 1 << CAUSE_W;

  logic [NUM_MODES-1:0] modes_q;
  logic [MASK_W-1:0]    mask_q;
  logic                 match;

  always_ff @(posedge clk) begin
    if (rst) begin
      modes_q <= '0;
      mask_q  <= '0;
    end else if (wr_i) begin
      modes_q <= clr_i ? '0 : wr_modes_i;
      mask_q  <= clr_i ? '0 : wr_mask_i;
    end
  end

  generate
    if (HAS_NMI) begin : g_nmi
      logic nmi_q;
      always_ff @(posedge clk) begin
        if (rst)       nmi_q <= 1'b0;
        else if (wr_i) nmi_q <= clr_i ? 1'b0 : wr_nmi_i;
      end
      assign match = ev_nmi_i ? nmi_q : mask_q[cause_i];
    end else begin : g_plain
      logic unused_nmi;
      assign unused_nmi = wr_nmi_i ^ ev_nmi_i;
      assign match      = mask_q[cause_i];
    end
  endgenerate

  assign fire_o = ev_i && !dbg_i && |(modes_q & mode_oh_i) && match;
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int CAUSE_W = 5,
  parameter int CNT_W   = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we_i,
  input  logic [1:0]              cfg_sel_i,
  input  logic                    cfg_clear_i,
  input  logic [4:0]              cfg_modes_i,
  input  logic                    cfg_nmi_i,
  input  logic                    cfg_pending_i,
  input  logic [(1<<CAUSE_W)-1:0] cfg_data_i,
  input  logic                    retire_i,
  input  logic                    irq_taken_i,
  input  logic                    irq_nmi_i,
  input  logic                    exc_taken_i,
  input  logic [CAUSE_W-1:0]      cause_i,
  input  logic [2:0]              priv_i,
  input  logic                    debug_mode_i,
  output logic                    halt_req_o,
  output logic [2:0]              hit_o
);
  localparam int MASK_W = 1 << CAUSE_W;

  logic [NUM_MODES-1:0] mode_oh;
  logic [NUM_TRIG-1:0]  fire;
  logic [NUM_TRIG-1:0]  hit_q;
  logic                 halt_q;
  logic                 wr_cnt, wr_irq, wr_exc;

  assign wr_cnt = cfg_we_i && (cfg_sel_i == SEL_COUNT);
  assign wr_irq = cfg_we_i && (cfg_sel_i == SEL_IRQ);
  assign wr_exc = cfg_we_i && (cfg_sel_i == SEL_EXC);

  dbg_trig_mode_dec u_mode (
    .priv_i    (priv_i),
    .mode_oh_o (mode_oh)
  );

  dbg_trig_icount #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (wr_cnt),
    .clr_i      (cfg_clear_i),
    .wr_modes_i (cfg_modes_i),
    .wr_pend_i  (cfg_pending_i),
    .wr_count_i (cfg_data_i[CNT_W-1:0]),
    .retire_i   (retire_i),
    .mode_oh_i  (mode_oh),
    .dbg_i      (debug_mode_i),
    .fire_o     (fire[HIT_COUNT])
  );

  dbg_trig_cause #(.CAUSE_W(CAUSE_W), .HAS_NMI(1'b1)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (wr_irq),
    .clr_i      (cfg_clear_i),
    .wr_modes_i (cfg_modes_i),
    .wr_mask_i  (cfg_data_i[MASK_W-1:0]),
    .wr_nmi_i   (cfg_nmi_i),
    .ev_i       (irq_taken_i),
    .ev_nmi_i   (irq_nmi_i),
    .cause_i    (cause_i),
    .mode_oh_i  (mode_oh),
    .dbg_i      (debug_mode_i),
    .fire_o     (fire[HIT_IRQ])
  );

  dbg_trig_cause #(.CAUSE_W(CAUSE_W), .HAS_NMI(1'b0)) u_exc (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (wr_exc),
    .clr_i      (cfg_clear_i),
    .wr_modes_i (cfg_modes_i),
    .wr_mask_i  (cfg_data_i[MASK_W-1:0]),
    .wr_nmi_i   (1'b0),
    .ev_i       (exc_taken_i),
    .ev_nmi_i   (1'b0),
    .cause_i    (cause_i),
    .mode_oh_i  (mode_oh),
    .dbg_i      (debug_mode_i),
    .fire_o     (fire[HIT_EXC])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      hit_q  <= fire;
      halt_q <= |fire;
    end
  end

  assign hit_o      = hit_q;
  assign halt_req_o = halt_q;
endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_taken_i,
  input logic       exc_taken_i,
  input logic       debug_mode_i,
  input logic       halt_req_o,
  input logic [2:0] hit_o
);
  // R1: a reset edge leaves the request low
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !halt_req_o);

  // R8: nothing fires out of a debug-mode cycle
  p_no_hit_in_debug_r8: assert property (@(posedge clk) disable iff (rst)
    $past(debug_mode_i) |-> (hit_o == 3'b000));

  // R3: an exception hit needs a taken exception one edge earlier
  p_exc_cause_r3: assert property (@(posedge clk) disable iff (rst)
    hit_o[2] |-> $past(exc_taken_i));

  // R4: an interrupt hit needs a taken interrupt one edge earlier
  p_irq_cause_r4: assert property (@(posedge clk) disable iff (rst)
    hit_o[1] |-> $past(irq_taken_i));

  // R10: request and hit vector agree
  p_halt_matches_hits_r10: assert property (@(posedge clk) disable iff (rst)
    halt_req_o == (hit_o != 3'b000));
endmodule

bind dbg_trig_unit dbg_trig_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_taken_i  (irq_taken_i),
  .exc_taken_i  (exc_taken_i),
  .debug_mode_i (debug_mode_i),
  .halt_req_o   (halt_req_o),
  .hit_o        (hit_o)
);

// File: tb/tb_dbg_trig_unit.sv
module tb_dbg_trig_unit;
  localparam int CAUSE_W = 5;
  localparam int CNT_W   = 14;
  localparam int MASK_W  = 1 << CAUSE_W;
  localparam int NVEC    = 12;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_we, cfg_clear, cfg_nmi, cfg_pending;
  logic [1:0]        cfg_sel;
  logic [4:0]        cfg_modes;
  logic [MASK_W-1:0] cfg_data;
  logic              retire, irq_taken, irq_nmi, exc_taken, dbg;
  logic [CAUSE_W-1:0] cause;
  logic [2:0]        priv;
  logic              halt_req;
  logic [2:0]        hit;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbg_trig_unit #(.CAUSE_W(CAUSE_W), .CNT_W(CNT_W)) dut (
    .clk (clk), .rst (rst),
    .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel), .cfg_clear_i (cfg_clear),
    .cfg_modes_i (cfg_modes), .cfg_nmi_i (cfg_nmi), .cfg_pending_i (cfg_pending),
    .cfg_data_i (cfg_data), .retire_i (retire), .irq_taken_i (irq_taken),
    .irq_nmi_i (irq_nmi), .exc_taken_i (exc_taken), .cause_i (cause),
    .priv_i (priv), .debug_mode_i (dbg), .halt_req_o (halt_req), .hit_o (hit)
  );

  // {exc, nmi_opt, nmi_ev, modes[4:0], priv[2:0], cause[4:0], mask_bit[4:0], expect}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 5'b00001, 3'd3, 5'd2,  5'd2,  1'b1},
    {1'b1, 1'b0, 1'b0, 5'b00001, 3'd0, 5'd2,  5'd2,  1'b0},
    {1'b1, 1'b0, 1'b0, 5'b00100, 3'd0, 5'd13, 5'd13, 1'b1},
    {1'b1, 1'b0, 1'b0, 5'b11111, 3'd5, 5'd7,  5'd8,  1'b0},
    {1'b1, 1'b0, 1'b0, 5'b01000, 3'd5, 5'd31, 5'd31, 1'b1},
    {1'b1, 1'b0, 1'b0, 5'b10000, 3'd4, 5'd0,  5'd0,  1'b1},
    {1'b1, 1'b0, 1'b0, 5'b00010, 3'd5, 5'd3,  5'd3,  1'b0},
    {1'b0, 1'b0, 1'b0, 5'b00001, 3'd3, 5'd7,  5'd7,  1'b1},
    {1'b0, 1'b0, 1'b0, 5'b00010, 3'd1, 5'd9,  5'd5,  1'b0},
    {1'b0, 1'b1, 1'b1, 5'b00001, 3'd3, 5'd0,  5'd11, 1'b1},
    {1'b0, 1'b0, 1'b1, 5'b00001, 3'd3, 5'd11, 5'd11, 1'b0},
    {1'b0, 1'b1, 1'b1, 5'b00100, 3'd3, 5'd0,  5'd0,  1'b0}
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic clr, input logic [4:0] modes,
                     input logic nmi, input logic pend, input logic [MASK_W-1:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_clear = clr; cfg_modes = modes;
    cfg_nmi = nmi; cfg_pending = pend; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_clear = 1'b0;
  endtask

  // one event cycle; outputs for it are visible on return
  task automatic ev(input logic ret, input logic irq, input logic nmi, input logic exc,
                    input logic [CAUSE_W-1:0] c, input logic [2:0] p);
    retire = ret; irq_taken = irq; irq_nmi = nmi; exc_taken = exc; cause = c; priv = p;
    @(negedge clk);
    retire = 1'b0; irq_taken = 1'b0; irq_nmi = 1'b0; exc_taken = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_clear = 0; cfg_modes = 0; cfg_nmi = 0;
    cfg_pending = 0; cfg_data = '0; retire = 0; irq_taken = 0; irq_nmi = 0;
    exc_taken = 0; dbg = 0; cause = '0; priv = 3'd3;
    repeat (3) @(negedge clk);
    check("R1 reset hits", hit, 3'b000);
    check("R1 reset halt", {2'b0, halt_req}, 3'b000);
    rst = 1'b0;
    ev(1'b1, 1'b1, 1'b0, 1'b1, 5'd4, 3'd3);
    check("R1 empty triggers silent", hit, 3'b000);

    // vector walk over the cause triggers (R2 R3 R4 R5)
    for (int i = 0; i < NVEC; i++) begin
      logic [21:0] v;
      logic [MASK_W-1:0] m;
      v = VEC[i];
      m = '0; m[v[5:1]] = 1'b1;
      cfg(2'd2, 1'b1, 5'b0, 1'b0, 1'b0, '0);
      cfg(2'd3, 1'b1, 5'b0, 1'b0, 1'b0, '0);
      cfg(v[21] ? 2'd3 : 2'd2, 1'b0, v[18:14], v[20], 1'b0, m);
      ev(1'b0, !v[21], v[19], v[21], v[10:6], v[13:11]);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), hit,
            v[0] ? (v[21] ? 3'b100 : 3'b010) : 3'b000);
      check($sformatf("R10 vector %0d halt", i), {2'b0, halt_req}, {2'b0, v[0]});
    end
    cfg(2'd2, 1'b1, 5'b0, 1'b0, 1'b0, '0);
    cfg(2'd3, 1'b1, 5'b0, 1'b0, 1'b0, '0);

    // R6 count of 3 in M, with ignored retirements between
    cfg(2'd1, 1'b0, 5'b00001, 1'b0, 1'b0, 3);
    ev(1'b1, 0, 0, 0, '0, 3'd3);
    check("R6 after 1 of 3", hit, 3'b000);
    ev(1'b1, 0, 0, 0, '0, 3'd3);
    check("R6 after 2 of 3", hit, 3'b000);
    ev(1'b1, 0, 0, 0, '0, 3'd0);
    check("R6 disabled mode not counted", hit, 3'b000);
    dbg = 1'b1;
    ev(1'b1, 0, 0, 0, '0, 3'd3);
    dbg = 1'b0;
    check("R8 debug retire not counted", hit, 3'b000);
    ev(1'b1, 0, 0, 0, '0, 3'd3);
    check("R6 third counted retire fires", hit, 3'b001);
    check("R10 halt with count hit", {2'b0, halt_req}, 3'b001);
    idle();
    check("R7 pending holds hit", hit, 3'b001);
    dbg = 1'b1;
    idle();
    check("R8 pending masked in debug", hit, 3'b000);
    dbg = 1'b0;
    idle();
    check("R8 pending resumes after debug", hit, 3'b001);
    cfg(2'd1, 1'b1, 5'b11111, 1'b1, 1'b1, 5);
    idle();
    check("R9 count trigger cleared", hit, 3'b000);
    ev(1'b1, 0, 0, 0, '0, 3'd3);
    check("R9 cleared count ignores retire", hit, 3'b000);

    // R6 boundary: count 1
    cfg(2'd1, 1'b0, 5'b00010, 1'b0, 1'b0, 1);
    ev(1'b1, 0, 0, 0, '0, 3'd1);
    check("R6 count of one fires at once", hit, 3'b001);
    cfg(2'd1, 1'b1, 5'b0, 1'b0, 1'b0, '0);

    // R7 direct pending write and zero count
    cfg(2'd1, 1'b0, 5'b00001, 1'b0, 1'b1, 0);
    check("R7 pending write edge+1", hit, 3'b000);
    idle();
    check("R7 pending write edge+2", hit, 3'b001);
    cfg(2'd1, 1'b0, 5'b00001, 1'b0, 1'b0, 0);
    idle();
    ev(1'b1, 0, 0, 0, '0, 3'd3);
    check("R7 zero count never fires", hit, 3'b000);

    // R9 exception clear
    cfg(2'd3, 1'b0, 5'b00001, 1'b0, 1'b0, 32'h10);
    cfg(2'd3, 1'b1, 5'b00001, 1'b0, 1'b0, 32'h10);
    ev(0, 0, 0, 1'b1, 5'd4, 3'd3);
    check("R9 cleared exception silent", hit, 3'b000);

    // R10 simultaneous interrupt and exception, then R8 debug blocks both
    cfg(2'd3, 1'b0, 5'b00001, 1'b0, 1'b0, 32'h40);
    cfg(2'd2, 1'b0, 5'b00001, 1'b0, 1'b0, 32'h40);
    ev(0, 1'b1, 0, 1'b1, 5'd6, 3'd3);
    check("R10 both cause hits", hit, 3'b110);
    check("R10 halt on both", {2'b0, halt_req}, 3'b001);
    dbg = 1'b1;
    ev(0, 1'b1, 0, 1'b1, 5'd6, 3'd3);
    dbg = 1'b0;
    check("R8 no cause hit in debug", hit, 3'b000);

    finish_run();
  end
endmodule